// File: doc/BRIEF.md
# Sleep Mode Entry and Exit Controller

This controller manages the power-down request of a synchronous memory core. The request pin is asynchronous and active high, and it is held low in normal operation. The controller passes the pin through a flop synchroniser. It then times a fixed entry latency and a fixed wake-up latency. While the core is not fully awake, it raises one signal that the core uses for three things: it ignores every synchronous input, it acts as deselected, and it puts its data outputs in high impedance.

The controller never clears or resets anything in the core. Array contents and pipeline registers keep their values across a sleep period. Any read or write still in the pipeline when entry begins may be lost. The controller samples a busy indication at that moment and raises a flag that stays up until the core is awake again, so the system can reissue the operation. If the request drops before entry completes, the controller moves straight into the wake-up countdown and never reports low power.

Top module: `sleep_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, ready is 1 and in_ignore, low_power and op_lost are 0.
- R2: A request that rises before rising edge 1 and stays high is acted on at edge 3. In the default setting (two synchroniser flops), in_ignore goes to 1 after edge 3 and ready goes to 0 at the same edge.
- R3: If the request is still high as seen through the synchroniser, low_power goes to 1 two edges after in_ignore rose. With the request high through edge L, where L is 3 or more, low_power is 1 after edges 5 through L+2.
- R4: A request that is high through edge L and low from edge L+1 onward keeps in_ignore at 1 up to and including edge L+4. Ready returns to 1 after edge L+5, which is two cycles of wake-up after the release reaches the controller.
- R5: ready is always the inverse of in_ignore, and low_power is never 1 unless in_ignore is 1.
- R6: If the request falls during the entry countdown (L of 1 or 2), low_power never rises, and the full wake-up countdown still applies (ready after edge L+5).
- R7: The op_busy input is sampled only at the edge where entry begins. If it was 1 there, op_lost is 1 from that edge until ready returns. At all other times op_busy has no effect on op_lost.
- R8: A request that rises again while wake-up is in progress does not shorten wake-up. Ready is 1 for at least one cycle, and entry begins again at the next edge.
- R9: low_power holds steady for as long as the request stays high, however long that is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Asynchronous active-high sleep request |
| op_busy | input | 1 | Core has a read or write in flight |
| in_ignore | output | 1 | Core ignores its inputs, acts deselected and tri-states its outputs |
| low_power | output | 1 | Core is fully in sleep |
| ready | output | 1 | Core is awake and samples its inputs |
| op_lost | output | 1 | An in-flight operation was cut off by sleep entry |

## Verification
The checker watches several relations on every cycle. It checks that ready and in_ignore are always exclusive, and that low_power only appears inside an ignore window. It checks that low_power rises only after two cycles of ignore, and that ready returns only after two cycles without low_power. It also checks that op_lost can only rise at the awake-to-entry edge. The exact edge counts depend on how long the request is held, and only the bench scenarios can show them. These include abort during entry, the unchanged flag under op_busy toggles, and re-entry right after wake-up.

// File: rtl/sleep_ctrl_pkg.sv
// Package: shared state type of the sleep controller.
package sleep_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_ENTER  = 2'd1,
        ST_ASLEEP = 2'd2,
        ST_WAKE   = 2'd3
    } slp_state_t;
endpackage

// File: rtl/sleep_sync.sv
// Flop chain that brings an asynchronous level into the clock domain.
// Assumes: the input is a level that is held for several cycles, not a pulse.
module sleep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: shift the level one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else if (g == 0) chain[g] <= async_in;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sleep_lat_cnt.sv
// Down counter that times a fixed entry or wake-up latency.
// Assumes: load and dec are never asserted together; done is valid at zero.
module sleep_lat_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Purpose: load a new latency or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sleep_ctrl.sv
// Sleep entry and exit controller for a synchronous memory core.
// Synchronises the request, times ENTRY_CYC cycles of entry and EXIT_CYC
// cycles of wake-up, and flags an in-flight operation at the start of entry.
// Assumes: the core gates its inputs, deselects itself and tri-states its
// outputs while in_ignore is 1, and that no storage is cleared during sleep.
module sleep_ctrl
    import sleep_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic op_busy,
    output logic in_ignore,
    output logic low_power,
    output logic ready,
    output logic op_lost
);
    localparam int MAXC = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
    localparam int CW   = $clog2(MAXC) + 1;
    localparam logic [CW-1:0] ENTRY_LD = CW'(ENTRY_CYC - 1);
    localparam logic [CW-1:0] EXIT_LD  = CW'(EXIT_CYC - 1);

    slp_state_t st_q, st_d;
    logic       req_s;
    logic       cnt_load, cnt_dec, cnt_done;
    logic [CW-1:0] cnt_val;
    logic       lost_q, lost_d;

    sleep_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sleep_req),
        .sync_out (req_s)
    );

    sleep_lat_cnt #(.W(CW)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .done     (cnt_done)
    );

    // Purpose: choose the next state, the counter action and the lost flag.
    always_comb begin
        st_d     = st_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = ENTRY_LD;
        lost_d   = lost_q;
        unique case (st_q)
            ST_AWAKE: if (req_s) begin
                st_d     = ST_ENTER;
                cnt_load = 1'b1;
                lost_d   = op_busy;
            end
            ST_ENTER: if (!req_s) begin
                st_d     = ST_WAKE;
                cnt_load = 1'b1;
                cnt_val  = EXIT_LD;
            end else if (cnt_done) begin
                st_d     = ST_ASLEEP;
            end else begin
                cnt_dec  = 1'b1;
            end
            ST_ASLEEP: if (!req_s) begin
                st_d     = ST_WAKE;
                cnt_load = 1'b1;
                cnt_val  = EXIT_LD;
            end
            ST_WAKE: if (cnt_done) begin
                st_d     = ST_AWAKE;
                lost_d   = 1'b0;
            end else begin
                cnt_dec  = 1'b1;
            end
            default: st_d = ST_AWAKE;
        endcase
    end

    // Purpose: hold the controller state and the lost-operation flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_AWAKE;
            lost_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            lost_q <= lost_d;
        end
    end

    assign in_ignore = (st_q != ST_AWAKE);
    assign ready     = (st_q == ST_AWAKE);
    assign low_power = (st_q == ST_ASLEEP);
    assign op_lost   = lost_q;
endmodule

// File: rtl/sleep_ctrl_chk.sv
// Checker for sleep_ctrl, attached to every instance by bind.
module sleep_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic in_ignore,
    input logic low_power,
    input logic ready,
    input logic op_lost
);
    assert_ready_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready != in_ignore);

    assert_lp_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |-> in_ignore);

    assert_entry_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_power) |-> ($past(in_ignore, 1) && $past(in_ignore, 2)));

    assert_wake_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(!low_power, 1) && $past(!low_power, 2)));

    assert_flag_at_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_lost) |-> ($past(ready) && in_ignore));

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(op_lost) |-> ready);
endmodule

bind sleep_ctrl sleep_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ignore (in_ignore),
    .low_power (low_power),
    .ready     (ready),
    .op_lost   (op_lost)
);

// File: tb/sleep_ctrl_tb_top.sv
// Bench: sweeps the request hold length and checks every edge arithmetically.
module sleep_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic op_busy = 1'b0;
    logic in_ignore, low_power, ready, op_lost;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sleep_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .op_busy   (op_busy),
        .in_ignore (in_ignore),
        .low_power (low_power),
        .ready     (ready),
        .op_lost   (op_lost)
    );

    task automatic chk(input bit act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hang expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        chk(ready, 1'b1, "R1 ready in reset");
        chk(in_ignore, 1'b0, "R1 in_ignore in reset");
        chk(low_power, 1'b0, "R1 low_power in reset");
        chk(op_lost, 1'b0, "R1 op_lost in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready, 1'b1, "R1 ready after reset");
        chk(op_lost, 1'b0, "R1 op_lost after reset");

        // Sweep over hold length L: request is high for edges 1..L.
        for (int L = 1; L <= 14; L++) begin
            op_busy   = L[0];
            sleep_req = 1'b1;
            for (int e = 1; e <= L + 8; e++) begin
                @(posedge clk);
                @(negedge clk);
                if (e == L) sleep_req = 1'b0;
                if (e >= 4) op_busy = ~op_busy; // R7: toggles after entry have no effect
                begin
                    bit ign_e, lp_e, lost_e;
                    ign_e  = (e >= 3) && (e <= L + 4);
                    lp_e   = (L >= 3) && (e >= 5) && (e <= L + 2);
                    lost_e = ign_e && L[0];
                    // R2 entry edge, R4 wake edge, R6 aborted entry
                    chk(in_ignore, ign_e, $sformatf("R2/R4 in_ignore L=%0d e=%0d", L, e));
                    chk(ready, !ign_e, $sformatf("R4 R6 ready L=%0d e=%0d", L, e));
                    // R3 low power window, R9 held steady
                    chk(low_power, lp_e, $sformatf("R3 R9 low_power L=%0d e=%0d", L, e));
                    chk(op_lost, lost_e, $sformatf("R7 op_lost L=%0d e=%0d", L, e));
                end
            end
            op_busy = 1'b0;
            repeat (3) @(negedge clk);
        end

        // R7: op_busy toggling while awake never sets the flag
        for (int i = 0; i < 6; i++) begin
            op_busy = ~op_busy;
            @(negedge clk);
            chk(op_lost, 1'b0, "R7 op_lost while awake");
        end
        op_busy = 1'b0;

        // R8: request high edges 1..4, low 5..7, high again from edge 8.
        sleep_req = 1'b1;
        for (int e = 1; e <= 14; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (e == 4) sleep_req = 1'b0;
            if (e == 7) sleep_req = 1'b1;
            begin
                bit rdy_e, lp_e;
                rdy_e = (e <= 2) || (e == 9);
                lp_e  = (e >= 5 && e <= 6) || (e >= 12);
                chk(ready, rdy_e, $sformatf("R8 ready e=%0d", e));
                chk(low_power, lp_e, $sformatf("R8 low_power e=%0d", e));
            end
        end
        sleep_req = 1'b0;
        repeat (8) @(negedge clk);
        chk(ready, 1'b1, "R8 ready after final release");
        finish_run();
    end
endmodule